// File: doc/BRIEF.md
# Accumulator Instruction Sequencer Core

This block is a small multi-cycle processor that executes a short program held in a program memory outside the block. Every instruction goes through the same seven steps. The steps are: fetch into the instruction register, advance the program counter, decode, form the operand address, read the operand, execute, and write back. The sequence then starts again. Program memory and data memory are separate address spaces, each reached through its own port. After reset, execution begins at program address 100. Data is kept at low data addresses.

The core has five 8-bit registers, A to E. Register A is the accumulator and is the only place an ALU result can be written. Load instructions can write any of the five registers. A three-bit status value records the zero, carry and negative outcome of the most recent ALU instruction. Debug outputs show the program counter, the instruction register, the accumulator and the flags, so a bench or a tile-level monitor can follow execution step by step.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous reset sets the program counter to 100 and clears the instruction register, registers A to E and the flags. Execution then restarts at the fetch step.
- R2: Each instruction takes exactly seven clock cycles.
  - The instruction register captures program memory at the address given by the program counter.
  - The program counter then advances by one.
  - After the write-back step, the next fetch follows.
- R3: The instruction word is 16 bits, laid out as follows:
  - bits 15:12 are the opcode;
  - bits 11:9 are the destination register;
  - bits 8:6 are the source register;
  - bits 5:0 are an immediate value or data address.
  - Registers are numbered A=0, B=1, C=2, D=3, E=4.
  - Opcode 1 (load immediate) writes the zero-extended 6-bit immediate into the destination register.
- R4: Opcode 2 (load from data memory) writes the data word at the 6-bit address into the destination register.
- R5: Opcodes 3 (add), 4 (subtract), 5 (bitwise AND) and 6 (bitwise XOR) combine A with the source register and write the 8-bit result into A. The destination field is ignored.
- R6: Opcode 7 (store) writes the source register to the 6-bit data address. It raises the write strobe for exactly one cycle per store.
- R7: The flags are arranged as follows:
  - bit 0 is zero: the result equals 0;
  - bit 1 is carry: the carry out of bit 7 for add, A less than source (unsigned) for subtract, and 0 for AND and XOR;
  - bit 2 is negative: bit 7 of the result.
- R8: Flags change only on opcodes 3 to 6. Loads, stores and no-ops leave them unchanged.
- R9: The following have no effect:
  - Opcodes 0 and 8 to 15 act as no-ops. They change no register, flag or data memory, and the program counter still advances.
  - Register numbers 5 to 7 read as 0.
  - Loads that name registers 5 to 7 write nothing.
- R10: The program "load A with 10, load B with 15, add B to A, store A at data address 20" leaves 25 in A and 25 at data address 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pmem_addr | output | 8 | Program memory read address (the program counter) |
| pmem_rdata | input | 16 | Program memory read data, combinational from pmem_addr |
| dmem_addr | output | 6 | Data memory address |
| dmem_wdata | output | 8 | Data memory write data |
| dmem_we | output | 1 | Data memory write strobe, one cycle per store |
| dmem_rdata | input | 8 | Data memory read data, combinational from dmem_addr |
| dbg_pc | output | 8 | Current program counter |
| dbg_ir | output | 16 | Current instruction register |
| dbg_acc | output | 8 | Register A |
| dbg_flags | output | 3 | Flags {negative, carry, zero} |

## Verification
Several effects coincide at the write-back edge of an ALU instruction. The accumulator write and the flag update land together, and when the source register is A itself, the operand read earlier in the same instruction sees the value the write-back then replaces. A store that directly follows an ALU instruction must carry the newly written accumulator. A load that directly follows must keep the flags the ALU instruction just produced. Seeded random programs place add, subtract, AND, XOR, loads, stores, out-of-range register numbers and undefined opcodes back to back. After every instruction, the bench compares A, the flags, the program counter and the instruction register with a reference model in the bench. It also compares the whole data memory and the number of write strobes at the end of each program.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W  = 4;
   localparam int RSEL_W = 3;
   localparam int FLG_W  = 3;
   localparam int FLG_Z  = 0;
   localparam int FLG_C  = 1;
   localparam int FLG_N  = 2;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP = 4'd0,
      OP_LDI = 4'd1,
      OP_LDM = 4'd2,
      OP_ADD = 4'd3,
      OP_SUB = 4'd4,
      OP_AND = 4'd5,
      OP_XOR = 4'd6,
      OP_STO = 4'd7
   } opc_e;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_INCPC  = 3'd1,
      ST_DECODE = 3'd2,
      ST_ADDR   = 3'd3,
      ST_READ   = 3'd4,
      ST_EXEC   = 3'd5,
      ST_WB     = 3'd6
   } step_e;

   function automatic logic is_alu(input opc_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_XOR);
   endfunction

   function automatic opc_e norm_opc(input logic [OPC_W-1:0] raw);
      return (raw > 4'd7) ? OP_NOP : opc_e'(raw);
   endfunction

endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
   import acc_cpu_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   output step_e st
);

   step_e st_nx;

   always_comb begin
      case (st)
         ST_FETCH:  st_nx = ST_INCPC;
         ST_INCPC:  st_nx = ST_DECODE;
         ST_DECODE: st_nx = ST_ADDR;
         ST_ADDR:   st_nx = ST_READ;
         ST_READ:   st_nx = ST_EXEC;
         ST_EXEC:   st_nx = ST_WB;
         default:   st_nx = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= ST_FETCH;
      else     st <= st_nx;
   end

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int REG_CNT = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [RSEL_W-1:0] wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [RSEL_W-1:0] rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] acc
);

   logic [DATA_W-1:0] rq [REG_CNT];

   for (genvar gi = 0; gi < REG_CNT; gi++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            rq[gi] <= '0;
         else if (wr_en && (wr_sel == RSEL_W'(gi)))
            rq[gi] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < REG_CNT; i++)
         if (rd_sel == RSEL_W'(i)) rd_data = rq[i];
   end

   assign acc = rq[0];

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  opc_e              op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic [FLG_W-1:0]  flg
);

   logic [DATA_W:0] wide;

   always_comb begin
      case (op)
         OP_ADD:  wide = {1'b0, a} + {1'b0, b};
         OP_SUB:  wide = {1'b0, a} - {1'b0, b};
         OP_AND:  wide = {1'b0, a & b};
         OP_XOR:  wide = {1'b0, a ^ b};
         default: wide = {1'b0, a};
      endcase
      res        = wide[DATA_W-1:0];
      flg[FLG_Z] = (res == '0);
      flg[FLG_C] = wide[DATA_W];
      flg[FLG_N] = res[DATA_W-1];
   end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PC_W     = 8,
   parameter int IMM_W    = 6,
   parameter int REG_CNT  = 5,
   parameter int RESET_PC = 100
) (
   input  logic                              clk,
   input  logic                              rst,
   output logic [PC_W-1:0]                   pmem_addr,
   input  logic [OPC_W+2*RSEL_W+IMM_W-1:0]   pmem_rdata,
   output logic [IMM_W-1:0]                  dmem_addr,
   output logic [DATA_W-1:0]                 dmem_wdata,
   output logic                              dmem_we,
   input  logic [DATA_W-1:0]                 dmem_rdata,
   output logic [PC_W-1:0]                   dbg_pc,
   output logic [OPC_W+2*RSEL_W+IMM_W-1:0]   dbg_ir,
   output logic [DATA_W-1:0]                 dbg_acc,
   output logic [FLG_W-1:0]                  dbg_flags
);

   localparam int INSTR_W = OPC_W + 2*RSEL_W + IMM_W;
   localparam int SRC_LSB = IMM_W;
   localparam int DST_LSB = IMM_W + RSEL_W;
   localparam int OPC_LSB = IMM_W + 2*RSEL_W;

   if (DATA_W <= IMM_W) begin : g_bad_width
      $error("acc_cpu: DATA_W must exceed IMM_W");
   end
   if ((REG_CNT < 1) || (REG_CNT > (1 << RSEL_W))) begin : g_bad_regs
      $error("acc_cpu: REG_CNT out of range");
   end
   if (RESET_PC >= (1 << PC_W)) begin : g_bad_pc
      $error("acc_cpu: RESET_PC does not fit PC_W");
   end

   step_e               st;
   logic [PC_W-1:0]     pc_q;
   logic [INSTR_W-1:0]  ir_q;
   opc_e                opc_q;
   logic [IMM_W-1:0]    maddr_q;
   logic [DATA_W-1:0]   opnd_q;
   logic [DATA_W-1:0]   res_q;
   logic [FLG_W-1:0]    aflg_q;
   logic [FLG_W-1:0]    flags_q;

   logic [RSEL_W-1:0]   dst_sel;
   logic [RSEL_W-1:0]   src_sel;
   logic [IMM_W-1:0]    imm;
   logic [DATA_W-1:0]   imm_ext;
   logic [DATA_W-1:0]   rd_data;
   logic [DATA_W-1:0]   acc;
   logic [DATA_W-1:0]   alu_res;
   logic [FLG_W-1:0]    alu_flg;
   logic                rf_we;
   logic [RSEL_W-1:0]   rf_sel;

   assign dst_sel = ir_q[DST_LSB +: RSEL_W];
   assign src_sel = ir_q[SRC_LSB +: RSEL_W];
   assign imm     = ir_q[IMM_W-1:0];
   assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm};

   acc_cpu_seq u_seq (
      .clk (clk),
      .rst (rst),
      .st  (st)
   );

   acc_cpu_regs #(
      .DATA_W  (DATA_W),
      .REG_CNT (REG_CNT)
   ) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (rf_we),
      .wr_sel  (rf_sel),
      .wr_data (res_q),
      .rd_sel  (src_sel),
      .rd_data (rd_data),
      .acc     (acc)
   );

   acc_cpu_alu #(
      .DATA_W (DATA_W)
   ) u_alu (
      .op  (opc_q),
      .a   (acc),
      .b   (opnd_q),
      .res (alu_res),
      .flg (alu_flg)
   );

   // write-back: ALU results go to A, loads to the named register
   always_comb begin
      rf_we  = (st == ST_WB) &&
               ((opc_q == OP_LDI) || (opc_q == OP_LDM) || is_alu(opc_q));
      rf_sel = is_alu(opc_q) ? '0 : dst_sel;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= PC_W'(RESET_PC);
         ir_q    <= '0;
         opc_q   <= OP_NOP;
         maddr_q <= '0;
         opnd_q  <= '0;
         res_q   <= '0;
         aflg_q  <= '0;
         flags_q <= '0;
      end else begin
         case (st)
            ST_FETCH:  ir_q    <= pmem_rdata;
            ST_INCPC:  pc_q    <= pc_q + 1'b1;
            ST_DECODE: opc_q   <= norm_opc(ir_q[OPC_LSB +: OPC_W]);
            ST_ADDR:   maddr_q <= imm;
            ST_READ: begin
               case (opc_q)
                  OP_LDI:  opnd_q <= imm_ext;
                  OP_LDM:  opnd_q <= dmem_rdata;
                  default: opnd_q <= rd_data;
               endcase
            end
            ST_EXEC: begin
               if (is_alu(opc_q)) begin
                  res_q  <= alu_res;
                  aflg_q <= alu_flg;
               end else begin
                  res_q  <= opnd_q;
               end
            end
            ST_WB: begin
               if (is_alu(opc_q)) flags_q <= aflg_q;
            end
            default: ;
         endcase
      end
   end

   assign pmem_addr  = pc_q;
   assign dmem_addr  = maddr_q;
   assign dmem_wdata = opnd_q;
   assign dmem_we    = (st == ST_WB) && (opc_q == OP_STO);

   assign dbg_pc    = pc_q;
   assign dbg_ir    = ir_q;
   assign dbg_acc   = acc;
   assign dbg_flags = flags_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PC_W     = 8,
   parameter int RESET_PC = 100
) (
   input logic              clk,
   input logic              rst,
   input logic [PC_W-1:0]   pc,
   input logic [DATA_W-1:0] acc,
   input logic [FLG_W-1:0]  flags,
   input logic              we,
   input step_e             st
);

   // R1
   rst_state_chk: assert property (@(posedge clk)
      rst |=> (pc == PC_W'(RESET_PC)) && (acc == '0) && (flags == '0) && (st == ST_FETCH));

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_INCPC) |=> (pc == PC_W'($past(pc) + 1'b1)));

   // R2
   pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st != ST_INCPC) |=> $stable(pc));

   // R2
   st_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_WB) |=> (st == ST_FETCH));

   // R6
   we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      we |=> !we);

   // R8
   flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st != ST_WB) |=> $stable(flags));

   // R5
   acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st != ST_WB) |=> $stable(acc));

endmodule

bind acc_cpu acc_cpu_chk #(
   .DATA_W   (DATA_W),
   .PC_W     (PC_W),
   .RESET_PC (RESET_PC)
) u_chk (
   .clk   (clk),
   .rst   (rst),
   .pc    (dbg_pc),
   .acc   (dbg_acc),
   .flags (dbg_flags),
   .we    (dmem_we),
   .st    (st)
);

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  pmem_addr;
   logic [15:0] pmem_rdata;
   logic [5:0]  dmem_addr;
   logic [7:0]  dmem_wdata;
   logic        dmem_we;
   logic [7:0]  dmem_rdata;
   logic [7:0]  dbg_pc;
   logic [15:0] dbg_ir;
   logic [7:0]  dbg_acc;
   logic [2:0]  dbg_flags;

   logic [15:0] pmem [256];
   logic [7:0]  dmem [64];
   int          wr_cnt;

   logic [7:0]  ref_r [8];
   logic [2:0]  ref_f;
   logic [7:0]  ref_d [64];
   int          ref_st;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   acc_cpu uut (
      .clk(clk), .rst(rst),
      .pmem_addr(pmem_addr), .pmem_rdata(pmem_rdata),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
      .dmem_rdata(dmem_rdata),
      .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_acc(dbg_acc), .dbg_flags(dbg_flags)
   );

   assign pmem_rdata = pmem[pmem_addr];
   assign dmem_rdata = dmem[dmem_addr];

   always @(posedge clk) begin
      if (dmem_we) begin
         dmem[dmem_addr] <= dmem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
   end

   function automatic logic [15:0] mk(input int op, input int d, input int s, input int im);
      return {op[3:0], d[2:0], s[2:0], im[5:0]};
   endfunction

   // {flags, result}; flags = {neg, carry, zero}
   function automatic logic [10:0] alu_ref(input int op, input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r;
      logic       c;
      case (op)
         3: begin r = a + b; c = (int'(a) + int'(b)) > 255; end
         4: begin r = a - b; c = (a < b); end
         5: begin r = a & b; c = 1'b0; end
         default: begin r = a ^ b; c = 1'b0; end
      endcase
      return {r[7], c, (r == 8'd0), r};
   endfunction

   task automatic ref_step(input logic [15:0] w);
      int op, d, s, im;
      logic [10:0] o;
      op = int'(w[15:12]); d = int'(w[11:9]); s = int'(w[8:6]); im = int'(w[5:0]);
      case (op)
         1: if (d < 5) ref_r[d] = 8'(im);
         2: if (d < 5) ref_r[d] = ref_d[im];
         3, 4, 5, 6: begin
            o = alu_ref(op, ref_r[0], ref_r[s]);
            ref_r[0] = o[7:0];
            ref_f = o[10:8];
         end
         7: begin ref_d[im] = ref_r[s]; ref_st++; end
         default: ;
      endcase
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 256; i++) pmem[i] = 16'h0000;
   endtask

   task automatic set_data(input int a, input int v);
      dmem[a]  = 8'(v);
      ref_d[a] = 8'(v);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #2;
      for (int i = 0; i < 8; i++) ref_r[i] = 8'd0;
      ref_f  = 3'd0;
      ref_st = 0;
      wr_cnt = 0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   // run one instruction (7 cycles) and compare against the reference
   task automatic step_chk(input int k, input string tag);
      repeat (7) @(posedge clk);
      #2;
      ref_step(pmem[100 + k]);
      chk({tag, " acc"},   int'(dbg_acc),   int'(ref_r[0]));
      chk({tag, " flags"}, int'(dbg_flags), int'(ref_f));
      chk({tag, " R2 pc"}, int'(dbg_pc),    100 + k + 1);
      chk({tag, " R2 ir"}, int'(dbg_ir),    int'(pmem[100 + k]));
   endtask

   task automatic mem_chk(input string tag);
      int diff = 0;
      for (int i = 0; i < 64; i++) if (dmem[i] !== ref_d[i]) diff++;
      chk({tag, " R6 dmem mismatches"}, diff, 0);
      chk({tag, " R6 write strobes"}, wr_cnt, ref_st);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 64; i++) set_data(i, 0);

      // R1 reset state
      clear_prog();
      do_reset();
      rst = 1'b1;
      @(posedge clk); #2;
      chk("R1 pc",    int'(dbg_pc),    100);
      chk("R1 acc",   int'(dbg_acc),   0);
      chk("R1 flags", int'(dbg_flags), 0);
      chk("R1 ir",    int'(dbg_ir),    0);

      // R10 reference program
      clear_prog();
      pmem[100] = mk(1, 0, 0, 10);
      pmem[101] = mk(1, 1, 0, 15);
      pmem[102] = mk(3, 0, 1, 0);
      pmem[103] = mk(7, 0, 0, 20);
      do_reset();
      for (int k = 0; k < 4; k++) step_chk(k, "R10 R3 R5 R6");
      chk("R10 A", int'(dbg_acc), 25);
      chk("R10 dmem[20]", int'(dmem[20]), 25);
      mem_chk("R10");

      // R4 R7 R8 R9 directed flag corners
      set_data(5, 200); set_data(6, 56); set_data(7, 128);
      clear_prog();
      pmem[100] = mk(2, 0, 0, 5);   // A=200
      pmem[101] = mk(2, 2, 0, 6);   // C=56
      pmem[102] = mk(3, 0, 2, 0);   // 256 -> 0, Z C
      pmem[103] = mk(1, 3, 0, 0);   // load keeps flags
      pmem[104] = mk(2, 0, 0, 7);   // A=128
      pmem[105] = mk(1, 1, 0, 1);   // B=1
      pmem[106] = mk(3, 0, 1, 0);   // 129, N
      pmem[107] = mk(4, 0, 2, 0);   // 73
      pmem[108] = mk(1, 0, 0, 3);   // A=3
      pmem[109] = mk(1, 4, 0, 63);  // E=63
      pmem[110] = mk(4, 0, 4, 0);   // 196, borrow and N
      pmem[111] = mk(5, 0, 2, 0);   // AND 56 -> 0
      pmem[112] = mk(6, 0, 1, 0);   // XOR 1 -> 1
      pmem[113] = mk(12, 0, 0, 0);  // undefined opcode
      pmem[114] = mk(1, 6, 0, 33);  // write to missing register
      pmem[115] = mk(3, 0, 6, 0);   // A + 0
      pmem[116] = mk(7, 0, 4, 9);   // store E
      pmem[117] = mk(7, 0, 6, 10);  // store missing register
      do_reset();
      for (int k = 0; k < 18; k++) begin
         step_chk(k, "R4 R7 R8 R9");
         if (k == 2)  chk("R7 add wrap flags", int'(dbg_flags), 3'b011);
         if (k == 3)  chk("R8 load keeps flags", int'(dbg_flags), 3'b011);
         if (k == 6)  chk("R7 negative flags", int'(dbg_flags), 3'b100);
         if (k == 10) chk("R7 borrow flags", int'(dbg_flags), 3'b110);
         if (k == 11) chk("R7 and zero flags", int'(dbg_flags), 3'b001);
         if (k == 13) chk("R9 nop acc", int'(dbg_acc), 1);
      end
      chk("R6 dmem[9]", int'(dmem[9]), 63);
      chk("R9 dmem[10]", int'(dmem[10]), 0);
      mem_chk("R9");

      // random programs, R2..R9
      for (int p = 0; p < 4; p++) begin
         for (int i = 0; i < 64; i++) set_data(i, int'($urandom() & 8'hFF));
         clear_prog();
         for (int k = 0; k < 48; k++)
            pmem[100 + k] = 16'($urandom());
         do_reset();
         for (int k = 0; k < 48; k++) step_chk(k, "random R2 R5 R7 R8 R9");
         mem_chk("random R4 R6");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #4_000_000;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule